// File: doc/BRIEF.md
# Command Ring Fetcher with Read-Pointer Writeback

This block pulls 32-bit command words out of a circular ring that lives in host memory. It keeps its own byte read offset into the ring. The host moves a write offset forward through a doorbell input. While the two offsets differ, the fetcher issues one single-word memory read at a time. It hands each returned word to a downstream consumer and then steps its read offset forward, wrapping at the ring size. The ring size is a power of two in bytes, given as a log2 value.

Each time the ring runs dry, the fetcher drops its busy flag and posts its read offset to a host-visible address through a one-word memory write. The posted value is the byte offset divided by four, so it counts dwords. This gives the host an up-to-date view of free ring space for every ring, including rings that are never torn down. A writeback address of zero turns the posting off.

A side entry lets the fetcher divert into an indirect buffer, given as a base address and a byte length. Words come from that buffer until its length is used up. The fetcher then returns to the main ring. The indirect buffer has no effect on the ring read offset.

Top module: `cmd_ring_fetcher`

## Requirements
- R1: While and right after synchronous reset, `rd_req_valid`, `word_valid`, `wb_valid` and `busy` are all low, and the read and write offsets are zero.
- R2: The ring counts as having work whenever the read offset is not equal to the write offset. A write offset numerically below the read offset therefore makes the fetcher read up to the ring end, wrap to offset 0 and stop at the write offset.
- R3: Each ring read requests exactly one 4-byte word at `cfg_ring_base + read_offset`. After the word is accepted, the read offset advances by 4 modulo 2^`cfg_size_lg` bytes. The doorbell value is also taken modulo that size.
- R4: A fetched word is shown on `word_data` with `word_valid` and is held unchanged until `word_ready`. No new read request is raised while a word is waiting.
- R5: When the offsets become equal after fetching, `busy` falls and a write request is raised at `cfg_wb_addr`. Its `wb_data` equals the read offset shifted right by 2, zero-extended to 32 bits.
- R6: When `cfg_wb_addr` is zero, a drain clears `busy` but raises no write request.
- R7: A pulse on `ib_go` while not already in the indirect buffer enters it, with base `ib_base` and length `ib_len` rounded down to a multiple of 4. Words are then read from `ib_base + k*4` for k = 0, 1, ... until the length is used. The fetcher then leaves the buffer and resumes the ring. An `ib_go` pulse that arrives while the buffer is active is ignored.
- R8: A doorbell that arrives while idle leads to a read request: `rd_req_valid` is low after the first rising edge that samples the doorbell and high after the second.
- R9: At most one memory request is outstanding at any time. `rd_req_valid` and `wb_valid` are never high together. A raised write request holds its address and data until `wb_ready`.
- R10: A writeback is posted on every drain, not just the first, and each one carries the read offset reached at that drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | ADDR_W | Byte address of ring start |
| cfg_size_lg | input | LG_W | log2 of ring size in bytes (2..PTR_W) |
| cfg_wb_addr | input | ADDR_W | Writeback address, zero disables |
| db_valid | input | 1 | Doorbell strobe |
| db_wptr | input | PTR_W | New write offset in bytes |
| ib_go | input | 1 | Enter indirect buffer |
| ib_base | input | ADDR_W | Indirect buffer byte address |
| ib_len | input | PTR_W | Indirect buffer length in bytes |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_addr | output | ADDR_W | Read word address |
| rd_req_ready | input | 1 | Read request accepted |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 32 | Read data |
| word_valid | output | 1 | Fetched word valid |
| word_data | output | 32 | Fetched word |
| word_ready | input | 1 | Consumer takes word |
| wb_valid | output | 1 | Writeback request valid |
| wb_addr | output | ADDR_W | Writeback address |
| wb_data | output | 32 | Read offset in dwords |
| wb_ready | input | 1 | Writeback accepted |
| busy | output | 1 | Fetching in progress |

## Verification
The hardest case to reach is a drain that happens just after a wrap, where the write offset sits numerically below the read offset. A table of doorbells, carried across rows without reset, first walks the read offset near the top of a 64-byte ring. The next doorbell then points below it, and the bench checks that fetching wraps to offset 0 and that the posted dword count reflects the wrapped position. Indirect-buffer exit is reached by entering the buffer from an idle ring and pulsing the entry again mid-buffer, so that the ignored pulse and the return to an empty ring both show up at the ports.

// File: rtl/crf_pkg.sv
package crf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_OUT,
    ST_WB
  } crf_state_e;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = 32;
endpackage

// File: rtl/crf_ptr_track.sv
module crf_ptr_track #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned LG_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [LG_W-1:0]   cfg_size_lg,
  input  logic              db_valid,
  input  logic [PTR_W-1:0]  db_wptr,
  input  logic              ib_go,
  input  logic [ADDR_W-1:0] ib_base,
  input  logic [PTR_W-1:0]  ib_len,
  input  logic              adv_ring,
  input  logic              adv_ib,
  input  logic              ib_exit,
  output logic [PTR_W-1:0]  rptr_o,
  output logic [ADDR_W-1:0] ring_addr_o,
  output logic [ADDR_W-1:0] ib_addr_o,
  output logic              ring_pending_o,
  output logic              ib_mode_o,
  output logic              ib_pending_o
);
  import crf_pkg::*;

  localparam logic [PTR_W-1:0] STEP = PTR_W'(WORD_BYTES);

  logic [PTR_W-1:0]  rptr_q, wptr_q, ib_off_q, ib_len_q;
  logic [ADDR_W-1:0] ib_base_q;
  logic              ib_mode_q;
  logic [PTR_W:0]    size_full;
  logic [PTR_W-1:0]  mask;

  // ring size mask, 2^lg - 1 (lg == PTR_W gives all ones)
  always_comb begin
    size_full = (PTR_W+1)'(1) << cfg_size_lg;
    mask      = PTR_W'(size_full - 1'b1);
  end

  // ring offsets
  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q <= '0;
      wptr_q <= '0;
    end else begin
      if (db_valid) wptr_q <= db_wptr & mask;
      if (adv_ring) rptr_q <= (rptr_q + STEP) & mask;
    end
  end

  // indirect buffer state
  always_ff @(posedge clk) begin
    if (rst) begin
      ib_mode_q <= 1'b0;
      ib_off_q  <= '0;
      ib_len_q  <= '0;
      ib_base_q <= '0;
    end else if (ib_go && !ib_mode_q) begin
      ib_mode_q <= 1'b1;
      ib_off_q  <= '0;
      ib_len_q  <= {ib_len[PTR_W-1:2], 2'b00};
      ib_base_q <= ib_base;
    end else if (ib_exit) begin
      ib_mode_q <= 1'b0;
    end else if (adv_ib) begin
      ib_off_q  <= ib_off_q + STEP;
    end
  end

  assign rptr_o         = rptr_q;
  assign ring_addr_o    = cfg_ring_base + ADDR_W'(rptr_q);
  assign ib_addr_o      = ib_base_q + ADDR_W'(ib_off_q);
  assign ring_pending_o = (rptr_q != wptr_q);
  assign ib_mode_o      = ib_mode_q;
  assign ib_pending_o   = (ib_off_q != ib_len_q);
endmodule

// File: rtl/crf_fetch_fsm.sv
module crf_fetch_fsm #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PTR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_wb_addr,
  input  logic [PTR_W-1:0]  rptr,
  input  logic [ADDR_W-1:0] ring_addr,
  input  logic [ADDR_W-1:0] ib_addr,
  input  logic              ring_pending,
  input  logic              ib_mode,
  input  logic              ib_pending,
  output logic              rd_req_valid,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              word_valid,
  output logic [31:0]       word_data,
  input  logic              word_ready,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [31:0]       wb_data,
  input  logic              wb_ready,
  output logic              busy,
  output logic              adv_ring,
  output logic              adv_ib,
  output logic              ib_exit
);
  import crf_pkg::*;

  crf_state_e        state_q;
  logic              busy_q, src_ib_q;
  logic              rd_valid_q, word_valid_q, wb_valid_q;
  logic [ADDR_W-1:0] rd_addr_q, wb_addr_q;
  logic [31:0]       word_q, wb_data_q;
  logic              take_word;

  assign take_word = (state_q == ST_OUT) && word_ready;
  assign adv_ring  = take_word && !src_ib_q;
  assign adv_ib    = take_word && src_ib_q;
  assign ib_exit   = (state_q == ST_IDLE) && ib_mode && !ib_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      busy_q       <= 1'b0;
      src_ib_q     <= 1'b0;
      rd_valid_q   <= 1'b0;
      rd_addr_q    <= '0;
      word_valid_q <= 1'b0;
      word_q       <= '0;
      wb_valid_q   <= 1'b0;
      wb_addr_q    <= '0;
      wb_data_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ib_mode) begin
            if (ib_pending) begin
              rd_addr_q  <= ib_addr;
              src_ib_q   <= 1'b1;
              rd_valid_q <= 1'b1;
              busy_q     <= 1'b1;
              state_q    <= ST_REQ;
            end
          end else if (ring_pending) begin
            rd_addr_q  <= ring_addr;
            src_ib_q   <= 1'b0;
            rd_valid_q <= 1'b1;
            busy_q     <= 1'b1;
            state_q    <= ST_REQ;
          end else if (busy_q) begin
            busy_q <= 1'b0;
            if (cfg_wb_addr != '0) begin
              wb_addr_q  <= cfg_wb_addr;
              wb_data_q  <= 32'(rptr >> 2);
              wb_valid_q <= 1'b1;
              state_q    <= ST_WB;
            end
          end
        end
        ST_REQ: begin
          if (rd_req_ready) begin
            rd_valid_q <= 1'b0;
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rd_rsp_valid) begin
            word_q       <= rd_rsp_data;
            word_valid_q <= 1'b1;
            state_q      <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (word_ready) begin
            word_valid_q <= 1'b0;
            state_q      <= ST_IDLE;
          end
        end
        ST_WB: begin
          if (wb_ready) begin
            wb_valid_q <= 1'b0;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid = rd_valid_q;
  assign rd_req_addr  = rd_addr_q;
  assign word_valid   = word_valid_q;
  assign word_data    = word_q;
  assign wb_valid     = wb_valid_q;
  assign wb_addr      = wb_addr_q;
  assign wb_data      = wb_data_q;
  assign busy         = busy_q;
endmodule

// File: rtl/cmd_ring_fetcher.sv
module cmd_ring_fetcher #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PTR_W  = 16,
  localparam int unsigned LG_W  = $clog2(PTR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [LG_W-1:0]   cfg_size_lg,
  input  logic [ADDR_W-1:0] cfg_wb_addr,
  input  logic              db_valid,
  input  logic [PTR_W-1:0]  db_wptr,
  input  logic              ib_go,
  input  logic [ADDR_W-1:0] ib_base,
  input  logic [PTR_W-1:0]  ib_len,
  output logic              rd_req_valid,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              word_valid,
  output logic [31:0]       word_data,
  input  logic              word_ready,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [31:0]       wb_data,
  input  logic              wb_ready,
  output logic              busy
);
  logic [PTR_W-1:0]  rptr;
  logic [ADDR_W-1:0] ring_addr, ib_addr;
  logic              ring_pending, ib_mode, ib_pending;
  logic              adv_ring, adv_ib, ib_exit;

  crf_ptr_track #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .LG_W(LG_W)) ptr_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_ring_base (cfg_ring_base),
    .cfg_size_lg   (cfg_size_lg),
    .db_valid      (db_valid),
    .db_wptr       (db_wptr),
    .ib_go         (ib_go),
    .ib_base       (ib_base),
    .ib_len        (ib_len),
    .adv_ring      (adv_ring),
    .adv_ib        (adv_ib),
    .ib_exit       (ib_exit),
    .rptr_o        (rptr),
    .ring_addr_o   (ring_addr),
    .ib_addr_o     (ib_addr),
    .ring_pending_o(ring_pending),
    .ib_mode_o     (ib_mode),
    .ib_pending_o  (ib_pending)
  );

  crf_fetch_fsm #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) fsm_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_wb_addr  (cfg_wb_addr),
    .rptr         (rptr),
    .ring_addr    (ring_addr),
    .ib_addr      (ib_addr),
    .ring_pending (ring_pending),
    .ib_mode      (ib_mode),
    .ib_pending   (ib_pending),
    .rd_req_valid (rd_req_valid),
    .rd_req_addr  (rd_req_addr),
    .rd_req_ready (rd_req_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .word_valid   (word_valid),
    .word_data    (word_data),
    .word_ready   (word_ready),
    .wb_valid     (wb_valid),
    .wb_addr      (wb_addr),
    .wb_data      (wb_data),
    .wb_ready     (wb_ready),
    .busy         (busy),
    .adv_ring     (adv_ring),
    .adv_ib       (adv_ib),
    .ib_exit      (ib_exit)
  );
endmodule

// File: rtl/crf_checker.sv
module crf_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req_valid,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_req_ready,
  input logic              word_valid,
  input logic [31:0]       word_data,
  input logic              word_ready,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [31:0]       wb_data,
  input logic              wb_ready,
  input logic              busy
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !rd_req_valid && !word_valid && !wb_valid && !busy);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
    word_valid && !word_ready |=> word_valid && $stable(word_data));

  assert_no_read_while_word_R4: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> !rd_req_valid);

  assert_idle_on_wb_R5: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> !busy);

  assert_wb_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_valid) |-> wb_addr != '0);

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
    !(rd_req_valid && wb_valid));

  assert_wb_hold_R9: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));
endmodule

bind cmd_ring_fetcher crf_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .rd_req_valid (rd_req_valid),
  .rd_req_addr  (rd_req_addr),
  .rd_req_ready (rd_req_ready),
  .word_valid   (word_valid),
  .word_data    (word_data),
  .word_ready   (word_ready),
  .wb_valid     (wb_valid),
  .wb_addr      (wb_addr),
  .wb_data      (wb_data),
  .wb_ready     (wb_ready),
  .busy         (busy)
);

// File: tb/cmd_ring_fetcher_tb_top.sv
`timescale 1ns/1ps
module cmd_ring_fetcher_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned PTR_W  = 16;
  localparam int unsigned LG_W   = $clog2(PTR_W + 1);
  localparam logic [31:0] KEY    = 32'h5A5A_0000;
  localparam logic [31:0] RBASE  = 32'h0000_1000;
  localparam logic [31:0] WBA    = 32'h2000_0000;

  // rows: wptr, words, first offset, last offset, posted dwords
  localparam logic [31:0] VEC [0:3][0:4] = '{
    '{32'd16, 32'd3, 32'd4,  32'd12, 32'd4},
    '{32'd40, 32'd6, 32'd16, 32'd36, 32'd10},
    '{32'd8,  32'd8, 32'd40, 32'd4,  32'd2},
    '{32'd12, 32'd1, 32'd8,  32'd8,  32'd3}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] cfg_ring_base = RBASE;
  logic [LG_W-1:0]   cfg_size_lg = LG_W'(6);
  logic [ADDR_W-1:0] cfg_wb_addr = WBA;
  logic              db_valid = 1'b0;
  logic [PTR_W-1:0]  db_wptr = '0;
  logic              ib_go = 1'b0;
  logic [ADDR_W-1:0] ib_base = '0;
  logic [PTR_W-1:0]  ib_len = '0;
  logic              rd_req_valid;
  logic [ADDR_W-1:0] rd_req_addr;
  logic              rd_req_ready = 1'b1;
  logic              rd_rsp_valid = 1'b0;
  logic [31:0]       rd_rsp_data = '0;
  logic              word_valid;
  logic [31:0]       word_data;
  logic              word_ready = 1'b1;
  logic              wb_valid;
  logic [ADDR_W-1:0] wb_addr;
  logic [31:0]       wb_data;
  logic              wb_ready = 1'b1;
  logic              busy;

  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;
  bit          done = 1'b0;
  logic [31:0] cap [0:63];
  int          cap_n = 0;
  bit          wb_got = 1'b0;
  logic [31:0] wb_d, wb_a;
  bit          acc_pend = 1'b0;
  logic [31:0] acc_addr = '0;

  always #4 clk = ~clk;

  cmd_ring_fetcher #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) dut_i (.*);

  // memory model: one response the cycle after a request is taken
  always @(negedge clk) begin
    rd_rsp_valid = 1'b0;
    if (acc_pend) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = acc_addr ^ KEY;
      acc_pend     = 1'b0;
    end
    if (rd_req_valid && rd_req_ready) begin
      acc_pend = 1'b1;
      acc_addr = rd_req_addr;
    end
  end

  // capture consumer and writeback traffic
  always @(negedge clk) begin
    if (word_valid && word_ready && cap_n < 64) begin
      cap[cap_n] = word_data ^ KEY;
      cap_n++;
    end
    if (wb_valid && wb_ready) begin
      wb_got = 1'b1;
      wb_d   = wb_data;
      wb_a   = wb_addr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=<50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic ring_db(input logic [PTR_W-1:0] w);
    @(negedge clk);
    db_valid = 1'b1;
    db_wptr  = w;
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic wait_wb();
    int t = 0;
    while (!wb_got && t < 400) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_req_valid", 32'(rd_req_valid), 0);
    chk("R1 word_valid", 32'(word_valid), 0);
    chk("R1 wb_valid", 32'(wb_valid), 0);
    chk("R1 busy", 32'(busy), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", 32'(rd_req_valid | busy | wb_valid), 0);

    // R8 doorbell latency from idle
    cap_n = 0; wb_got = 0;
    ring_db(16'd4);
    chk("R8 no request after first edge", 32'(rd_req_valid), 0);
    @(negedge clk);
    chk("R8 request after second edge", 32'(rd_req_valid), 1);
    wait_wb();
    chk("R8 one word", 32'(cap_n), 1);
    chk("R3 word at base", cap[0], RBASE);
    chk("R5 first posting", wb_d, 32'd1);

    // table walk; rows carry the read offset forward (R10 each drain posts)
    for (int r = 0; r < 4; r++) begin
      string tag;
      tag = (r == 2) ? "R2 wrap" : "R3 ring";
      cap_n = 0; wb_got = 0;
      ring_db(VEC[r][0][PTR_W-1:0]);
      wait_wb();
      chk({tag, " count"}, 32'(cap_n), VEC[r][1]);
      chk({tag, " first addr"}, cap[0], RBASE + VEC[r][2]);
      chk({tag, " last addr"}, cap[cap_n > 0 ? cap_n-1 : 0], RBASE + VEC[r][3]);
      chk("R10 posted dwords", wb_d, VEC[r][4]);
      chk("R5 posting addr", wb_a, WBA);
    end

    // R4 consumer backpressure
    cap_n = 0; wb_got = 0;
    word_ready = 1'b0;
    ring_db(16'd16);
    begin
      int t = 0;
      while (!word_valid && t < 50) begin @(negedge clk); t++; end
    end
    begin
      logic [31:0] held;
      bit ok = 1'b1;
      held = word_data;
      repeat (5) begin
        @(negedge clk);
        if (!word_valid || word_data !== held || rd_req_valid) ok = 1'b0;
      end
      chk("R4 word held, no new read", 32'(ok), 1);
      chk("R4 held word value", held ^ KEY, RBASE + 32'd12);
    end
    word_ready = 1'b1;
    wait_wb();
    chk("R4 posting after release", wb_d, 32'd4);

    // R9 writeback backpressure
    cap_n = 0; wb_got = 0;
    wb_ready = 1'b0;
    ring_db(16'd20);
    begin
      int t = 0;
      while (!wb_valid && t < 50) begin @(negedge clk); t++; end
    end
    begin
      bit ok = 1'b1;
      repeat (5) begin
        @(negedge clk);
        if (!wb_valid || wb_data !== 32'd5 || wb_addr !== WBA || rd_req_valid) ok = 1'b0;
      end
      chk("R9 writeback held alone", 32'(ok), 1);
    end
    wb_ready = 1'b1;
    @(negedge clk);
    chk("R9 writeback taken", 32'(wb_got), 1);
    chk("R5 busy low at drain", 32'(busy), 0);

    // R6 disabled posting
    cfg_wb_addr = '0;
    cap_n = 0; wb_got = 0;
    ring_db(16'd24);
    begin
      bit saw = 1'b0;
      repeat (30) begin
        @(negedge clk);
        if (wb_valid) saw = 1'b1;
      end
      chk("R6 no writeback", 32'(saw), 0);
    end
    chk("R6 busy cleared", 32'(busy), 0);
    chk("R6 word fetched", 32'(cap_n), 1);
    cfg_wb_addr = WBA;

    // R7 indirect buffer from an empty ring, with ignored re-entry
    cap_n = 0; wb_got = 0;
    @(negedge clk);
    ib_go = 1'b1; ib_base = 32'h0000_8000; ib_len = 16'd14;
    @(negedge clk);
    ib_go = 1'b0;
    begin
      int t = 0;
      while (cap_n < 1 && t < 50) begin @(negedge clk); t++; end
    end
    ib_go = 1'b1; ib_base = 32'h0000_9000; ib_len = 16'd4;
    @(negedge clk);
    ib_go = 1'b0;
    wait_wb();
    chk("R7 buffer words", 32'(cap_n), 3);
    chk("R7 word 0", cap[0], 32'h0000_8000);
    chk("R7 word 1", cap[1], 32'h0000_8004);
    chk("R7 word 2", cap[2], 32'h0000_8008);
    chk("R7 ring offset untouched", wb_d, 32'd6);
    // ring resumes after buffer exit
    cap_n = 0; wb_got = 0;
    ring_db(16'd28);
    wait_wb();
    chk("R7 ring resumes", cap[0], RBASE + 32'd24);
    chk("R10 posting after resume", wb_d, 32'd7);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule